// File: doc/BRIEF.md
# Sideband Reply Segmenter

This block delivers a reply message of 1 to 256 bytes to a host that can only see a small reply window and a bank of event status bytes. The message is first written into an internal byte buffer, then a start strobe hands over its length and a one-bit sequence number. The block splits the message into chunks of at most 44 payload bytes. For each chunk it presents a 3-byte header, the payload and a trailing data CRC byte in the window. It then loads the status bytes, raises the reply-ready bit and pulses an interrupt.

The host reads the window, then acknowledges the chunk by writing ones to the status bits it wants cleared. The block builds the next chunk only once the reply-ready bit reads zero. A write of zero to the control register abandons the transfer at any point, including while the block waits for an acknowledge. Host accesses carry a 9-bit address: bit 8 clear selects the reply window and bit 8 set selects the status bank, with bits 7:0 as the byte offset. Every access gets a registered response one cycle later.

Top module: `sbr_reply_segmenter`

## Requirements
- R1: After reset `busy` and `irq` are low and every status byte reads 0x00.
- R2: A message of L bytes (1..256) goes out as ceil(L/44) chunks in byte order; every chunk carries 44 payload bytes except the last, which carries the remainder.
- R3: Window bytes 0..2 hold the header. Byte 0 is 0x10. Byte 1 is the payload count plus one, with bits 7:6 zero. In byte 2, bit 7 is set only on the first chunk, bit 6 only on the chunk holding the final byte, bit 5 is zero, bit 4 is the start sequence number, and bits 3:0 are a CRC with polynomial x^4+x+1, initial value 0, taken MSB first over the first five header nibbles.
- R4: Payload byte k sits at window offset 3+k. The byte after the payload is a CRC-8 with polynomial 0x1D5, initial value 0, taken MSB first over the payload. Any higher window offset reads 0x00.
- R5: When a chunk is published, status byte 0 holds the `port_cnt` value, byte 1 holds 0x10 (reply-ready is bit 4), and byte 2 holds 0x00. Status offsets 3..15 read 0x00.
- R6: `irq` is a single-cycle pulse, issued exactly once per chunk.
- R7: A status write clears the bits that are set in the written data. The next chunk is not published while bit 4 of status byte 1 stays set, including when other bits are written.
- R8: A control write of 0x00 aborts the transfer. `busy` is low from the next cycle and no further chunk is published. A non-zero control write has no effect.
- R9: A status access at offset 16 or above returns `h_nack` high and leaves the status unchanged. Offsets below 16 and window accesses are acknowledged.
- R10: `busy` rises when a message is accepted and falls after the final chunk's reply-ready bit is cleared.
- R11: A start strobe is ignored while busy or when `start_len` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| msg_we | input | 1 | Message buffer byte write strobe |
| msg_waddr | input | 8 | Message buffer byte index |
| msg_wdata | input | 8 | Message buffer byte value |
| start | input | 1 | Accept the buffered message |
| start_len | input | 9 | Message length in bytes |
| start_seq | input | 1 | Sequence number copied into every header |
| port_cnt | input | 8 | Value loaded into status byte 0 |
| h_rd | input | 1 | Host read strobe |
| h_wr | input | 1 | Host write strobe |
| h_addr | input | 9 | Bit 8: status bank; bits 7:0: offset |
| h_wdata | input | 8 | Host write data (ones clear status bits) |
| h_ack_vld | output | 1 | Response valid, one cycle after the access |
| h_nack | output | 1 | Access refused |
| h_rdata | output | 8 | Read data |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control write data; zero aborts |
| irq | output | 1 | One-cycle pulse per published chunk |
| busy | output | 1 | Transfer in progress |

## Verification
The bench goes after chunk boundaries: lengths of 5, 88 (an exact multiple of 44), 100 and 256. A design that sized or flagged chunks wrongly would show a stray empty chunk, a missing end flag or a shifted payload. The bench holds the reply-ready bit set for many cycles and writes other bits of it, so a design that advanced early would show an extra interrupt. Aborts are issued both mid-build and mid-wait. A second start during a transfer and zero-length starts are also driven: a design that honoured them would corrupt the second chunk's length or sequence bit, or leave `busy` stuck. Out-of-range status offsets must give a NACK without clearing the ready bit.

// File: rtl/sbr_pkg.sv
package sbr_pkg;

    localparam int SBR_MSG_MAX   = 256;
    localparam int SBR_CHUNK_MAX = 44;
    localparam int SBR_STAT_SPAN = 16;
    localparam int SBR_RDY_BIT   = 4;
    localparam int SBR_HDR_BYTES = 3;
    localparam logic [7:0] SBR_HDR_LINK = 8'h10;

    typedef enum logic [1:0] {
        SEG_IDLE  = 2'd0,
        SEG_BUILD = 2'd1,
        SEG_WAIT  = 2'd2
    } seg_state_e;

    typedef struct packed {
        logic       first;
        logic       last;
        logic       seq;
        logic [5:0] body_len;
    } chunk_hdr_t;

    function automatic logic [7:0] crc8_byte(input logic [7:0] acc, input logic [7:0] din);
        logic [7:0] c;
        c = acc ^ din;
        for (int b = 0; b < 8; b++) begin
            c = c[7] ? ((c << 1) ^ 8'hD5) : (c << 1);
        end
        return c;
    endfunction

endpackage

// File: rtl/sbr_hdr_crc4.sv
module sbr_hdr_crc4 (
    input  logic [19:0] nibbles,
    output logic [3:0]  crc
);
    always_comb begin
        logic [3:0] c;
        logic       fb;
        c = 4'h0;
        for (int k = 19; k >= 0; k--) begin
            fb = c[3] ^ nibbles[k];
            c  = {c[2:0], 1'b0} ^ (fb ? 4'h3 : 4'h0);
        end
        crc = c;
    end
endmodule

// File: rtl/sbr_data_crc8.sv
module sbr_data_crc8 import sbr_pkg::*; (
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       step,
    input  logic [7:0] din,
    output logic [7:0] crc_nxt
);
    logic [7:0] acc_q;

    assign crc_nxt = crc8_byte(acc_q, din);

    always_ff @(posedge clk) begin
        if (rst || clr) acc_q <= 8'h00;
        else if (step)  acc_q <= crc_nxt;
    end
endmodule

// File: rtl/sbr_evt_status.sv
module sbr_evt_status #(
    parameter int SPAN    = 16,
    parameter int RDY_BIT = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] port_cnt,
    input  logic       wr_en,
    input  logic [7:0] wr_off,
    input  logic [7:0] wr_data,
    input  logic [7:0] rd_off,
    output logic [7:0] rd_byte,
    output logic       rdy
);
    localparam int NBYTES = 3;

    logic [7:0] stat_q [NBYTES];

    assign rdy = stat_q[1][RDY_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NBYTES; i++) stat_q[i] <= 8'h00;
        end else if (load) begin
            stat_q[0] <= port_cnt;
            stat_q[1] <= 8'(1 << RDY_BIT);
            stat_q[2] <= 8'h00;
        end else if (wr_en && wr_off < 8'(NBYTES)) begin
            stat_q[wr_off[1:0]] <= stat_q[wr_off[1:0]] & ~wr_data;
        end
    end

    always_comb begin
        rd_byte = 8'h00;
        if (rd_off < 8'(NBYTES)) rd_byte = stat_q[rd_off[1:0]];
    end

    a_r7_clear_needs_w1c: assert property (@(posedge clk) disable iff (rst)
        $fell(rdy) |-> $past(wr_en && wr_off == 8'd1 && wr_data[RDY_BIT]));

    a_r9_range_guard: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> wr_off < 8'(SPAN));
endmodule

// File: rtl/sbr_reply_segmenter.sv
module sbr_reply_segmenter import sbr_pkg::*; #(
    parameter int MSG_MAX   = SBR_MSG_MAX,
    parameter int CHUNK_MAX = SBR_CHUNK_MAX,
    parameter int STAT_SPAN = SBR_STAT_SPAN,
    parameter int RDY_BIT   = SBR_RDY_BIT,
    localparam int AW = $clog2(MSG_MAX),
    localparam int LW = $clog2(MSG_MAX + 1),
    localparam int CW = $clog2(CHUNK_MAX + 2)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          msg_we,
    input  logic [AW-1:0] msg_waddr,
    input  logic [7:0]    msg_wdata,
    input  logic          start,
    input  logic [LW-1:0] start_len,
    input  logic          start_seq,
    input  logic [7:0]    port_cnt,
    input  logic          h_rd,
    input  logic          h_wr,
    input  logic [8:0]    h_addr,
    input  logic [7:0]    h_wdata,
    output logic          h_ack_vld,
    output logic          h_nack,
    output logic [7:0]    h_rdata,
    input  logic          ctrl_we,
    input  logic [7:0]    ctrl_wdata,
    output logic          irq,
    output logic          busy
);
    logic [7:0]    msg_mem [MSG_MAX];
    seg_state_e    state_q;
    logic [LW-1:0] len_q, pos_q, remain;
    logic [CW-1:0] cnt_q, n_q, clen;
    logic [AW-1:0] base_q, rd_idx;
    logic          seq_q, first_q, last_q, irq_q, busy_q;
    logic [7:0]    dcrc_q, crc_nxt, build_byte;
    logic          abort, start_ok, last_step, rdy;
    chunk_hdr_t    hdr;
    logic [3:0]    hcrc;
    logic [7:0]    hdr_b1, hdr_b2, win_byte, stat_byte, off, rel;
    logic          in_stat, off_bad;

    always_ff @(posedge clk) begin
        if (msg_we) msg_mem[msg_waddr] <= msg_wdata;
    end

    assign remain     = len_q - pos_q;
    assign clen       = (remain > LW'(CHUNK_MAX)) ? CW'(CHUNK_MAX) : CW'(remain);
    assign rd_idx     = AW'(pos_q) + AW'(cnt_q);
    assign build_byte = msg_mem[rd_idx];
    assign abort      = ctrl_we && (ctrl_wdata == 8'h00);
    assign start_ok   = start && (state_q == SEG_IDLE) && (start_len != '0)
                        && (start_len <= LW'(MSG_MAX));
    assign last_step  = (state_q == SEG_BUILD) && (cnt_q == clen - CW'(1));

    sbr_data_crc8 u_dcrc (
        .clk(clk), .rst(rst), .clr(state_q != SEG_BUILD),
        .step(state_q == SEG_BUILD), .din(build_byte), .crc_nxt(crc_nxt)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SEG_IDLE;
            len_q <= '0; pos_q <= '0; cnt_q <= '0; n_q <= '0; base_q <= '0;
            seq_q <= 1'b0; first_q <= 1'b0; last_q <= 1'b0;
            dcrc_q <= 8'h00; irq_q <= 1'b0; busy_q <= 1'b0;
        end else if (abort) begin
            state_q <= SEG_IDLE;
            irq_q   <= 1'b0;
            busy_q  <= 1'b0;
        end else begin
            irq_q <= 1'b0;
            case (state_q)
                SEG_IDLE: if (start_ok) begin
                    len_q   <= start_len;
                    seq_q   <= start_seq;
                    pos_q   <= '0;
                    cnt_q   <= '0;
                    busy_q  <= 1'b1;
                    state_q <= SEG_BUILD;
                end
                SEG_BUILD: if (last_step) begin
                    base_q  <= AW'(pos_q);
                    n_q     <= clen;
                    first_q <= (pos_q == '0);
                    last_q  <= (pos_q + LW'(clen) == len_q);
                    pos_q   <= pos_q + LW'(clen);
                    dcrc_q  <= crc_nxt;
                    irq_q   <= 1'b1;
                    state_q <= SEG_WAIT;
                end else begin
                    cnt_q <= cnt_q + CW'(1);
                end
                SEG_WAIT: if (!rdy) begin
                    cnt_q <= '0;
                    if (pos_q == len_q) begin
                        state_q <= SEG_IDLE;
                        busy_q  <= 1'b0;
                    end else begin
                        state_q <= SEG_BUILD;
                    end
                end
                default: state_q <= SEG_IDLE;
            endcase
        end
    end

    assign irq  = irq_q;
    assign busy = busy_q;

    // Host access decode
    assign in_stat = h_addr[8];
    assign off     = h_addr[7:0];
    assign off_bad = in_stat && (off >= 8'(STAT_SPAN));

    sbr_evt_status #(.SPAN(STAT_SPAN), .RDY_BIT(RDY_BIT)) u_stat (
        .clk(clk), .rst(rst), .load(last_step && !abort), .port_cnt(port_cnt),
        .wr_en(h_wr && in_stat && !off_bad), .wr_off(off), .wr_data(h_wdata),
        .rd_off(off), .rd_byte(stat_byte), .rdy(rdy)
    );

    // Reply window: header, payload mapped onto the buffer, data CRC
    assign hdr.first    = first_q;
    assign hdr.last     = last_q;
    assign hdr.seq      = seq_q;
    assign hdr.body_len = 6'(n_q + CW'(1));
    assign hdr_b1 = {2'b00, hdr.body_len};

    sbr_hdr_crc4 u_hcrc (
        .nibbles({SBR_HDR_LINK, hdr_b1, hdr.first, hdr.last, 1'b0, hdr.seq}),
        .crc(hcrc)
    );

    assign hdr_b2 = {hdr.first, hdr.last, 1'b0, hdr.seq, hcrc};
    assign rel    = off - 8'(SBR_HDR_BYTES);

    always_comb begin
        win_byte = 8'h00;
        if (off == 8'd0)                      win_byte = SBR_HDR_LINK;
        else if (off == 8'd1)                 win_byte = hdr_b1;
        else if (off == 8'd2)                 win_byte = hdr_b2;
        else if (rel < 8'(n_q))               win_byte = msg_mem[base_q + AW'(rel)];
        else if (rel == 8'(n_q))              win_byte = dcrc_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            h_ack_vld <= 1'b0;
            h_nack    <= 1'b0;
            h_rdata   <= 8'h00;
        end else begin
            h_ack_vld <= h_rd || h_wr;
            h_nack    <= (h_rd || h_wr) && off_bad;
            h_rdata   <= (h_rd && !off_bad) ? (in_stat ? stat_byte : win_byte) : 8'h00;
        end
    end

    a_r6_irq_one_cycle: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    a_r6_irq_with_ready: assert property (@(posedge clk) disable iff (rst)
        irq |-> (rdy && busy));

    a_r8_abort_idles: assert property (@(posedge clk) disable iff (rst)
        abort |=> (!busy && !irq));

    a_r2_chunk_cap: assert property (@(posedge clk) disable iff (rst)
        irq |-> (n_q != '0 && n_q <= CW'(CHUNK_MAX)));

    a_r10_busy_release: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(abort) || !rdy));

    a_r9_nack_range: assert property (@(posedge clk) disable iff (rst)
        (h_ack_vld && h_nack) |-> $past(h_addr[8] && h_addr[7:0] >= 8'(STAT_SPAN)));
endmodule

// File: tb/sim_sbr_reply_segmenter.sv
`timescale 1ns/1ps
module sim_sbr_reply_segmenter;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       msg_we = 1'b0;
    logic [7:0] msg_waddr = '0, msg_wdata = '0;
    logic       start = 1'b0;
    logic [8:0] start_len = '0;
    logic       start_seq = 1'b0;
    logic [7:0] port_cnt = 8'd3;
    logic       h_rd = 1'b0, h_wr = 1'b0;
    logic [8:0] h_addr = '0;
    logic [7:0] h_wdata = '0;
    logic       h_ack_vld, h_nack;
    logic [7:0] h_rdata;
    logic       ctrl_we = 1'b0;
    logic [7:0] ctrl_wdata = '0;
    logic       irq, busy;

    always #10 clk = ~clk;

    sbr_reply_segmenter u0 (
        .clk(clk), .rst(rst), .msg_we(msg_we), .msg_waddr(msg_waddr), .msg_wdata(msg_wdata),
        .start(start), .start_len(start_len), .start_seq(start_seq), .port_cnt(port_cnt),
        .h_rd(h_rd), .h_wr(h_wr), .h_addr(h_addr), .h_wdata(h_wdata),
        .h_ack_vld(h_ack_vld), .h_nack(h_nack), .h_rdata(h_rdata),
        .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .irq(irq), .busy(busy)
    );

    int n_chk = 0, n_bad = 0, irq_seen = 0;
    logic [7:0] tbm [256];

    always @(negedge clk) if (!rst && irq === 1'b1) irq_seen++;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] ref_crc8(int base, int n);
        logic [7:0] c = 8'h00;
        for (int i = 0; i < n; i++) begin
            c ^= tbm[base + i];
            for (int b = 0; b < 8; b++) c = c[7] ? ((c << 1) ^ 8'hD5) : (c << 1);
        end
        return c;
    endfunction

    function automatic logic [3:0] ref_crc4(logic [19:0] bits);
        logic [3:0] c = 4'h0;
        logic fb;
        for (int k = 19; k >= 0; k--) begin
            fb = c[3] ^ bits[k];
            c  = {c[2:0], 1'b0} ^ (fb ? 4'h3 : 4'h0);
        end
        return c;
    endfunction

    task automatic hrd(input logic [8:0] a, output logic [7:0] d, output logic nk);
        @(negedge clk); h_rd = 1'b1; h_addr = a;
        @(negedge clk); h_rd = 1'b0; d = h_rdata; nk = h_nack;
    endtask

    task automatic hwr(input logic [8:0] a, input logic [7:0] d, output logic nk);
        @(negedge clk); h_wr = 1'b1; h_addr = a; h_wdata = d;
        @(negedge clk); h_wr = 1'b0; nk = h_nack;
    endtask

    task automatic ctrl_write(input logic [7:0] d);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = d;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic load_msg(int len, int seed);
        for (int i = 0; i < len; i++) begin
            tbm[i] = 8'((i * 37 + seed * 11 + 5) & 255);
            @(negedge clk); msg_we = 1'b1; msg_waddr = 8'(i); msg_wdata = tbm[i];
        end
        @(negedge clk); msg_we = 1'b0;
    endtask

    task automatic kick(int len, logic seq);
        @(negedge clk); start = 1'b1; start_len = 9'(len); start_seq = seq;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_irq(int target, string tag);
        int t = 0;
        while (irq_seen < target && t < 300) begin @(negedge clk); t++; end
        chk({tag, " R6 interrupt arrives"}, irq_seen, target);
    endtask

    task automatic clear_ready();
        logic nk;
        hwr(9'h101, 8'h10, nk);
    endtask

    task automatic check_chunk(string tag, int pos, int len, logic seq);
        logic [7:0] d, b1, b2;
        logic nk;
        int n = (len - pos > 44) ? 44 : len - pos;
        logic fst = (pos == 0);
        logic lst = (pos + n == len);
        hrd(9'h100, d, nk); chk({tag, " R5 status0"}, d, port_cnt);
        hrd(9'h101, d, nk); chk({tag, " R5 status1"}, d, 8'h10);
        hrd(9'h102, d, nk); chk({tag, " R5 status2"}, d, 8'h00);
        hrd(9'h000, d, nk); chk({tag, " R3 hdr0"}, d, 8'h10);
        b1 = 8'(n + 1);
        hrd(9'h001, d, nk); chk({tag, " R3 hdr1 length"}, d, b1);
        b2 = {fst, lst, 1'b0, seq, 4'h0};
        b2[3:0] = ref_crc4({8'h10, b1, b2[7:4]});
        hrd(9'h002, d, nk); chk({tag, " R3 hdr2 flags crc4"}, d, b2);
        for (int k = 0; k < n; k++) begin
            hrd(9'(3 + k), d, nk); chk({tag, " R2 R4 payload"}, d, tbm[pos + k]);
        end
        hrd(9'(3 + n), d, nk); chk({tag, " R4 data crc8"}, d, ref_crc8(pos, n));
        hrd(9'(4 + n), d, nk); chk({tag, " R4 past crc"}, d, 8'h00);
        chk({tag, " R10 busy during wait"}, busy, 1'b1);
    endtask

    task automatic run_msg(string tag, int len, logic seq, int seed);
        int base = irq_seen;
        int nch = (len + 43) / 44;
        load_msg(len, seed);
        kick(len, seq);
        for (int c = 0; c < nch; c++) begin
            wait_irq(base + c + 1, tag);
            check_chunk(tag, c * 44, len, seq);
            clear_ready();
        end
        repeat (3) @(negedge clk);
        chk({tag, " R2 R6 chunk count"}, irq_seen - base, nch);
        chk({tag, " R10 busy released"}, busy, 1'b0);
    endtask

    task automatic t_reset();
        logic [7:0] d; logic nk;
        chk("R1 busy after reset", busy, 1'b0);
        chk("R1 irq after reset", irq, 1'b0);
        for (int o = 0; o < 3; o++) begin
            hrd(9'h100 + 9'(o), d, nk); chk("R1 status after reset", d, 8'h00);
        end
        hrd(9'h105, d, nk); chk("R5 spare status offset", d, 8'h00);
    endtask

    task automatic t_hold();
        logic [7:0] d; logic nk;
        int base = irq_seen;
        load_msg(100, 4);
        kick(100, 1'b0);
        wait_irq(base + 1, "hold");
        repeat (20) @(negedge clk);
        hwr(9'h101, 8'hEF, nk);
        hwr(9'h100, 8'hFF, nk);
        repeat (10) @(negedge clk);
        chk("R7 no advance while ready set", irq_seen, base + 1);
        hrd(9'h101, d, nk); chk("R7 ready bit kept", d, 8'h10);
        hrd(9'h100, d, nk); chk("R7 w1c clears status0", d, 8'h00);
        hrd(9'h110, d, nk); chk("R9 read offset 16 nack", nk, 1'b1);
        hrd(9'h10F, d, nk); chk("R9 offset 15 acked", nk, 1'b0);
        chk("R9 offset 15 data", d, 8'h00);
        hwr(9'h114, 8'hFF, nk); chk("R9 write offset 20 nack", nk, 1'b1);
        hrd(9'h101, d, nk); chk("R9 refused write no effect", d, 8'h10);
        hrd(9'h003, d, nk); chk("R9 window acked", nk, 1'b0);
        clear_ready();
        wait_irq(base + 2, "hold");
        check_chunk("hold c1", 44, 100, 1'b0);
        clear_ready();
        wait_irq(base + 3, "hold");
        check_chunk("hold c2", 88, 100, 1'b0);
        clear_ready();
        repeat (3) @(negedge clk);
        chk("R10 busy released after hold", busy, 1'b0);
    endtask

    task automatic t_restart();
        int base = irq_seen;
        load_msg(50, 9);
        kick(50, 1'b0);
        wait_irq(base + 1, "restart");
        kick(3, 1'b1);
        check_chunk("R11 first", 0, 50, 1'b0);
        clear_ready();
        wait_irq(base + 2, "restart");
        check_chunk("R11 second", 44, 50, 1'b0);
        clear_ready();
        repeat (3) @(negedge clk);
        chk("R11 busy start ignored", irq_seen - base, 2);
        chk("R11 idle after", busy, 1'b0);
        kick(0, 1'b0);
        repeat (3) @(negedge clk);
        chk("R11 zero length ignored", busy, 1'b0);
    endtask

    task automatic t_abort();
        int base = irq_seen;
        load_msg(100, 2);
        kick(100, 1'b1);
        wait_irq(base + 1, "abort");
        ctrl_write(8'h05);
        repeat (2) @(negedge clk);
        chk("R8 nonzero control ignored", busy, 1'b1);
        ctrl_write(8'h00);
        chk("R8 abort drops busy", busy, 1'b0);
        clear_ready();
        repeat (150) @(negedge clk);
        chk("R8 no chunk after abort", irq_seen, base + 1);
        kick(100, 1'b0);
        ctrl_write(8'h00);
        repeat (100) @(negedge clk);
        chk("R8 abort mid build no irq", irq_seen, base + 1);
        chk("R8 idle after mid build abort", busy, 1'b0);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        run_msg("R2 short", 5, 1'b1, 1);
        port_cnt = 8'd7;
        run_msg("R2 exact88", 88, 1'b0, 3);
        port_cnt = 8'd3;
        t_hold();
        run_msg("R2 full256", 256, 1'b1, 6);
        t_restart();
        t_abort();
        run_msg("R8 after abort", 10, 1'b1, 8);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule